// File: doc/BRIEF.md
# Configuration Image Loader

This block pushes a configuration image into a programmable-logic target. It reads the image one byte at a time from a synchronous byte store, with one cycle of read latency. It looks for the first two-byte start marker `0xFF 0x20` and drops everything in front of it. It rejects an image whose payload, counted from the marker to the end, has an odd number of bytes. It then drives the target through reset, reload and program pulses and waits for the target to report that it is ready to be configured. After that it streams the payload as big-endian 16-bit words over a single-cycle write strobe.

The target reports a 16-bit status word. Its upper nibble tells which write handshake to use. A target on the newer interface gets a ready handshake before each word. An older target gets a fixed gap instead. After every word the loader checks that the target still reports it is in configuration. After the last word it waits for the target's done input. Every wait is bounded by a poll limit. A failed attempt restarts the whole sequence from the marker, up to a fixed number of attempts. The caller sees `busy`, then either a one-cycle `done_pulse` or a one-cycle `err_pulse` together with a 3-bit reason code.

Top module: `cfgld_loader`

## Requirements
- R1: After reset, `busy`, `done_pulse`, `err_pulse`, `tgt_wr`, `tgt_rst`, `tgt_reload` and `tgt_prog` are low, and `err_code` is 0.
- R2: If `mem_present` is low when `start` is sampled, `err_pulse` rises on the next cycle with `err_code` 7. No target pulse is issued.
- R3: The payload starts at the first byte index i where byte i is 0xFF and byte i+1 is 0x20. If no such pair exists, or the length is below 2, the result is `err_code` 1 with no target pulse.
- R4: If (length − i) is odd, the result is `err_code` 2 with no target pulse.
- R5: Each attempt drives `tgt_rst`, then `tgt_reload`, then `tgt_prog`. Each is high for PULSE_LEN cycles, back to back, and never more than one of these or `tgt_wr` at a time.
- R6: After the program pulse, status bit 1 (init) is sampled for at most INIT_TRIES cycles. If it is seen on the last of them the attempt goes on. If it is never seen, the attempt fails with code 3.
- R7: When status bits 15:12 equal 0x5 at the moment init is seen, each word waits for status bit 2 (ready) for at most READY_TRIES cycles. If ready is never seen, the attempt fails with code 4. Back-to-back writes then start 7 cycles apart when ready is already high.
- R8: For any other version nibble, ready is ignored. Each write follows a fixed OLD_GAP-cycle wait, so successive write strobes start OLD_GAP+6 cycles apart.
- R9: Words leave as {byte[p], byte[p+1]} for p = i, i+2, … up to the last byte, each on a single-cycle `tgt_wr`. The first word is therefore 0xFF20.
- R10: In the cycle after each write the init bit is sampled. If it is low, the attempt fails with code 5.
- R11: After the last word, `tgt_done` is sampled for at most DONE_TRIES cycles. If it is seen, `done_pulse` is raised; if not, the attempt fails with code 6.
- R12: A failed attempt (codes 3–6) restarts from the reset pulse and from the marker. Only the ATTEMPTS-th failure raises `err_pulse`, carrying the last code. Codes 1, 2 and 7 are never retried.
- R13: `busy` is high from the cycle after an accepted `start` until it falls in the cycle of the single `done_pulse` or `err_pulse`. `start` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while busy) |
| img_len | input | LEN_W | Image length in bytes |
| mem_present | input | 1 | Image store is present |
| img_addr | output | LEN_W | Byte address to the image store |
| img_rdata | input | 8 | Byte read, valid one cycle after the address |
| tgt_status | input | 16 | Target status: 15:12 version, 2 ready, 1 init |
| tgt_done | input | 1 | Target configuration complete |
| tgt_rst | output | 1 | Target-side reset pulse |
| tgt_reload | output | 1 | Target-side reload pulse |
| tgt_prog | output | 1 | Program pulse |
| tgt_wr | output | 1 | Word write strobe |
| tgt_wdata | output | 16 | Word being written |
| busy | output | 1 | Load in progress |
| done_pulse | output | 1 | Load succeeded (one cycle) |
| err_pulse | output | 1 | Load failed (one cycle) |
| err_code | output | 3 | Failure reason, held until the next start |

## Verification
Pre-checks answer one cycle after `start`. Storage and length faults show at the first sample point. Scan faults show two cycles per scanned byte later. Target pulses follow each other after exactly PULSE_LEN cycles. Write strobes are spaced 7 or OLD_GAP+6 cycles apart. Init, ready and done are honoured only within their poll windows, so the bench's target model raises each signal a chosen number of cycles after its trigger edge and tries both the last allowed cycle and the first one past it. All outputs are sampled at the falling edge, and the bench tallies pulses and write spacing against these cycle counts.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN_RQ, S_SCAN_CAP, S_RST, S_RLD, S_PRG, S_INIT,
    S_HI_RQ, S_HI_CAP, S_LO_RQ, S_LO_CAP, S_HSK, S_WRITE, S_CHECK, S_DONE
  } ld_state_t;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_NO_MARK   = 3'd1,
    E_ODD       = 3'd2,
    E_INIT_TO   = 3'd3,
    E_READY_TO  = 3'd4,
    E_INIT_LOST = 3'd5,
    E_DONE_TO   = 3'd6,
    E_NO_STORE  = 3'd7
  } ld_err_t;

  localparam logic [7:0] MARK_B0    = 8'hFF;
  localparam logic [7:0] MARK_B1    = 8'h20;
  localparam logic [3:0] NEW_IF_VER = 4'h5;
  localparam int         ST_INIT    = 1;
  localparam int         ST_READY   = 2;

endpackage

// File: rtl/cfgld_count.sv
module cfgld_count #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end
endmodule

// File: rtl/cfgld_word_pack.sv
module cfgld_word_pack #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_hi,
  input  logic          ld_lo,
  input  logic [BW-1:0] byte_in,
  output logic [2*BW-1:0] word
);
  logic [BW-1:0] hi_q, lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q <= '0;
      lo_q <= '0;
    end else begin
      if (ld_hi) hi_q <= byte_in;
      if (ld_lo) lo_q <= byte_in;
    end
  end

  assign word = {hi_q, lo_q};
endmodule

// File: rtl/cfgld_loader.sv
module cfgld_loader
  import cfgld_pkg::*;
#(
  parameter int LEN_W       = 16,
  parameter int PULSE_LEN   = 16,
  parameter int INIT_TRIES  = 50,
  parameter int READY_TRIES = 100,
  parameter int DONE_TRIES  = 200,
  parameter int OLD_GAP     = 32,
  parameter int ATTEMPTS    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] img_len,
  input  logic             mem_present,
  output logic [LEN_W-1:0] img_addr,
  input  logic [7:0]       img_rdata,
  input  logic [15:0]      tgt_status,
  input  logic             tgt_done,
  output logic             tgt_rst,
  output logic             tgt_reload,
  output logic             tgt_prog,
  output logic             tgt_wr,
  output logic [15:0]      tgt_wdata,
  output logic             busy,
  output logic             done_pulse,
  output logic             err_pulse,
  output logic [2:0]       err_code
);

  localparam int TMAX_A = (PULSE_LEN > INIT_TRIES) ? PULSE_LEN : INIT_TRIES;
  localparam int TMAX_B = (READY_TRIES > DONE_TRIES) ? READY_TRIES : DONE_TRIES;
  localparam int TMAX_C = (TMAX_A > TMAX_B) ? TMAX_A : TMAX_B;
  localparam int TMAX   = (TMAX_C > OLD_GAP) ? TMAX_C : OLD_GAP;
  localparam int T_W    = $clog2(TMAX + 1);
  localparam int A_W    = $clog2(ATTEMPTS + 1);

  localparam logic [T_W-1:0] PULSE_LAST = T_W'(PULSE_LEN - 1);
  localparam logic [T_W-1:0] INIT_LAST  = T_W'(INIT_TRIES - 1);
  localparam logic [T_W-1:0] READY_LAST = T_W'(READY_TRIES - 1);
  localparam logic [T_W-1:0] DONE_LAST  = T_W'(DONE_TRIES - 1);
  localparam logic [T_W-1:0] GAP_LAST   = T_W'(OLD_GAP - 1);
  localparam logic [A_W-1:0] ATT_LAST   = A_W'(ATTEMPTS - 1);

  ld_state_t        st, st_n;
  logic [LEN_W-1:0] ptr_q, ptr_nv, len_q, mark_q, ptr_m1;
  logic [7:0]       prev_q;
  logic             new_q;
  logic [T_W-1:0]   t_q;
  logic [A_W-1:0]   a_q;

  logic    ptr_ld, prev_ld, mark_ld, hi_ld, lo_ld, new_ld, go;
  logic    a_clr, a_inc, fin_ok, fin_err, att_fail, marker_hit;
  ld_err_t code_n, fail_code;

  logic init_bit, ready_bit, status_unused;
  assign init_bit      = tgt_status[ST_INIT];
  assign ready_bit     = tgt_status[ST_READY];
  assign status_unused = ^{tgt_status[11:3], tgt_status[0]};

  assign ptr_m1     = ptr_q - 1'b1;
  assign marker_hit = (ptr_q != '0) && (prev_q == MARK_B0) && (img_rdata == MARK_B1);

  // Cycle counter for the current state: cleared on every state change.
  cfgld_count #(.W(T_W)) u_tcnt (
    .clk (clk), .rst (rst), .clr (st_n != st), .inc (1'b1), .q (t_q)
  );

  // Failed-attempt counter.
  cfgld_count #(.W(A_W)) u_acnt (
    .clk (clk), .rst (rst), .clr (a_clr), .inc (a_inc), .q (a_q)
  );

  cfgld_word_pack #(.BW(8)) u_pack (
    .clk (clk), .rst (rst), .ld_hi (hi_ld), .ld_lo (lo_ld),
    .byte_in (img_rdata), .word (tgt_wdata)
  );

  always_comb begin
    st_n      = st;
    ptr_ld    = 1'b0;
    ptr_nv    = ptr_q;
    prev_ld   = 1'b0;
    mark_ld   = 1'b0;
    hi_ld     = 1'b0;
    lo_ld     = 1'b0;
    new_ld    = 1'b0;
    go        = 1'b0;
    a_clr     = 1'b0;
    a_inc     = 1'b0;
    fin_ok    = 1'b0;
    fin_err   = 1'b0;
    att_fail  = 1'b0;
    code_n    = E_NONE;
    fail_code = E_NONE;
    case (st)
      S_IDLE: if (start) begin
        go    = 1'b1;
        a_clr = 1'b1;
        if (!mem_present) begin
          fin_err = 1'b1;
          code_n  = E_NO_STORE;
        end else if (img_len < LEN_W'(2)) begin
          fin_err = 1'b1;
          code_n  = E_NO_MARK;
        end else begin
          ptr_ld = 1'b1;
          ptr_nv = '0;
          st_n   = S_SCAN_RQ;
        end
      end
      S_SCAN_RQ: st_n = S_SCAN_CAP;
      S_SCAN_CAP: begin
        if (marker_hit) begin
          mark_ld = 1'b1;
          if (len_q[0] ^ ptr_m1[0]) begin
            fin_err = 1'b1;
            code_n  = E_ODD;
            st_n    = S_IDLE;
          end else begin
            st_n = S_RST;
          end
        end else if (ptr_q == len_q - 1'b1) begin
          fin_err = 1'b1;
          code_n  = E_NO_MARK;
          st_n    = S_IDLE;
        end else begin
          prev_ld = 1'b1;
          ptr_ld  = 1'b1;
          ptr_nv  = ptr_q + 1'b1;
          st_n    = S_SCAN_RQ;
        end
      end
      S_RST: if (t_q == PULSE_LAST) st_n = S_RLD;
      S_RLD: if (t_q == PULSE_LAST) st_n = S_PRG;
      S_PRG: if (t_q == PULSE_LAST) st_n = S_INIT;
      S_INIT: begin
        if (init_bit) begin
          new_ld = 1'b1;
          ptr_ld = 1'b1;
          ptr_nv = mark_q;
          st_n   = S_HI_RQ;
        end else if (t_q == INIT_LAST) begin
          att_fail  = 1'b1;
          fail_code = E_INIT_TO;
        end
      end
      S_HI_RQ: st_n = S_HI_CAP;
      S_HI_CAP: begin
        hi_ld  = 1'b1;
        ptr_ld = 1'b1;
        ptr_nv = ptr_q + 1'b1;
        st_n   = S_LO_RQ;
      end
      S_LO_RQ: st_n = S_LO_CAP;
      S_LO_CAP: begin
        lo_ld = 1'b1;
        st_n  = S_HSK;
      end
      S_HSK: begin
        if (new_q) begin
          if (ready_bit) st_n = S_WRITE;
          else if (t_q == READY_LAST) begin
            att_fail  = 1'b1;
            fail_code = E_READY_TO;
          end
        end else if (t_q == GAP_LAST) begin
          st_n = S_WRITE;
        end
      end
      S_WRITE: st_n = S_CHECK;
      S_CHECK: begin
        if (!init_bit) begin
          att_fail  = 1'b1;
          fail_code = E_INIT_LOST;
        end else if (ptr_q == len_q - 1'b1) begin
          st_n = S_DONE;
        end else begin
          ptr_ld = 1'b1;
          ptr_nv = ptr_q + 1'b1;
          st_n   = S_HI_RQ;
        end
      end
      S_DONE: begin
        if (tgt_done) begin
          fin_ok = 1'b1;
          st_n   = S_IDLE;
        end else if (t_q == DONE_LAST) begin
          att_fail  = 1'b1;
          fail_code = E_DONE_TO;
        end
      end
      default: st_n = S_IDLE;
    endcase
    if (att_fail) begin
      code_n = fail_code;
      if (a_q == ATT_LAST) begin
        fin_err = 1'b1;
        st_n    = S_IDLE;
      end else begin
        a_inc = 1'b1;
        st_n  = S_RST;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ptr_q      <= '0;
      len_q      <= '0;
      mark_q     <= '0;
      prev_q     <= '0;
      new_q      <= 1'b0;
      busy       <= 1'b0;
      done_pulse <= 1'b0;
      err_pulse  <= 1'b0;
      err_code   <= 3'd0;
      tgt_rst    <= 1'b0;
      tgt_reload <= 1'b0;
      tgt_prog   <= 1'b0;
      tgt_wr     <= 1'b0;
    end else begin
      st <= st_n;
      if (ptr_ld)  ptr_q  <= ptr_nv;
      if (go)      len_q  <= img_len;
      if (prev_ld) prev_q <= img_rdata;
      if (mark_ld) mark_q <= ptr_m1;
      if (new_ld)  new_q  <= (tgt_status[15:12] == NEW_IF_VER);
      if (fin_err)  err_code <= code_n;
      else if (go)  err_code <= 3'd0;
      busy       <= (st_n != S_IDLE);
      done_pulse <= fin_ok;
      err_pulse  <= fin_err;
      tgt_rst    <= (st_n == S_RST);
      tgt_reload <= (st_n == S_RLD);
      tgt_prog   <= (st_n == S_PRG);
      tgt_wr     <= (st_n == S_WRITE);
    end
  end

  assign img_addr = ptr_q;

endmodule

// File: rtl/cfgld_loader_chk.sv
module cfgld_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done_pulse,
  input logic       err_pulse,
  input logic [2:0] err_code,
  input logic       tgt_wr,
  input logic       tgt_rst,
  input logic       tgt_reload,
  input logic       tgt_prog
);

  // R13
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_pulse && err_pulse));

  // R13
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done_pulse || err_pulse));

  // R13
  wr_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_wr |-> busy);

  // R12
  err_code_set_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_code != 3'd0));

  // R5
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tgt_rst, tgt_reload, tgt_prog, tgt_wr}));

  // R5
  prog_after_reload_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_prog) |-> $past(tgt_reload));

  // R9
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_wr |=> !tgt_wr);

endmodule

bind cfgld_loader cfgld_loader_chk u_chk (.*);

// File: tb/cfgld_loader_bench.sv
`timescale 1ns/1ps
module cfgld_loader_bench;

  localparam int LW = 6, PL = 2, IT = 5, RT = 6, DT = 7, GP = 3, AT = 3;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, mem_present = 1'b1;
  logic [LW-1:0] img_len = '0, img_addr;
  logic [7:0] img_rdata;
  logic [15:0] tgt_status, tgt_wdata;
  logic tgt_done, tgt_rst, tgt_reload, tgt_prog, tgt_wr;
  logic busy, done_pulse, err_pulse;
  logic [2:0] err_code;

  always #2 clk = ~clk;

  cfgld_loader #(.LEN_W(LW), .PULSE_LEN(PL), .INIT_TRIES(IT), .READY_TRIES(RT),
                 .DONE_TRIES(DT), .OLD_GAP(GP), .ATTEMPTS(AT)) u_cfgld_loader (
    .clk(clk), .rst(rst), .start(start), .img_len(img_len), .mem_present(mem_present),
    .img_addr(img_addr), .img_rdata(img_rdata), .tgt_status(tgt_status), .tgt_done(tgt_done),
    .tgt_rst(tgt_rst), .tgt_reload(tgt_reload), .tgt_prog(tgt_prog), .tgt_wr(tgt_wr),
    .tgt_wdata(tgt_wdata), .busy(busy), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .err_code(err_code));

  // image store, one cycle read latency
  logic [7:0] img [64];
  always @(posedge clk) img_rdata <= img[img_addr];

  // target model
  int init_dly = 1, init_skip = 0, done_dly = 1, exp_words = 1;
  bit done_en = 1, drop_mode = 0, rdy = 1;
  logic [3:0] ver = 4'h5;
  int pcnt, dcnt, prises_m, wa;
  bit lost, p_prev;
  logic init_b;
  always @(posedge clk) begin
    if (rst) begin
      pcnt <= 255; dcnt <= 255; prises_m <= 0; wa <= 0; lost <= 0; p_prev <= 0;
    end else begin
      p_prev <= tgt_prog;
      if (tgt_prog && !p_prev) prises_m <= prises_m + 1;
      if (tgt_prog) begin pcnt <= 0; lost <= 0; wa <= 0; end
      else if (pcnt < 255) pcnt <= pcnt + 1;
      if (tgt_wr) begin
        wa <= wa + 1; dcnt <= 0;
        if (drop_mode) lost <= 1;
      end else if (dcnt < 255) dcnt <= dcnt + 1;
    end
  end
  assign init_b     = (prises_m > init_skip) && (pcnt >= init_dly) && !lost;
  assign tgt_status = {ver, 9'd0, rdy, init_b, 1'b0};
  assign tgt_done   = done_en && (wa == exp_words) && (dcnt >= done_dly + 1);

  // monitor
  int cyc = 0, nw, n_done, n_err, n_prog, prg_w, t_rst, t_rld, t_prg, last_w, gmin, gmax;
  logic [2:0] last_code;
  logic [15:0] got [64];
  bit pr, pl, pp;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (tgt_wr) begin
        if (nw < 64) got[nw] = tgt_wdata;
        nw++;
        if (last_w >= 0) begin
          if (cyc - last_w < gmin) gmin = cyc - last_w;
          if (cyc - last_w > gmax) gmax = cyc - last_w;
        end
        last_w = cyc;
      end
      if (done_pulse) n_done++;
      if (err_pulse) begin n_err++; last_code = err_code; end
      if (tgt_rst && !pr) t_rst = cyc;
      if (tgt_reload && !pl) t_rld = cyc;
      if (tgt_prog && !pp) begin t_prg = cyc; n_prog++; end
      if (tgt_prog) prg_w++;
    end
    pr = tgt_rst; pl = tgt_reload; pp = tgt_prog;
  end

  int checks = 0, errors = 0;
  bit all_done = 0, first_err, busy0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic clr_mon();
    nw = 0; n_done = 0; n_err = 0; n_prog = 0; prg_w = 0; last_w = -1;
    gmin = 9999; gmax = -1; last_code = 3'd0; t_rst = 0; t_rld = 0; t_prg = 0;
  endtask

  function automatic logic [7:0] pb(input int j);
    return 8'h41 + 8'(j * 5);
  endfunction

  function automatic logic [15:0] exp_word(input int k);
    if (k == 0) return 16'hFF20;
    return {pb(2*k-2), pb(2*k-1)};
  endfunction

  task automatic build(input int off, input int plen);
    for (int i = 0; i < off; i++) img[i] = 8'h30 + 8'(i);
    img[off] = 8'hFF; img[off+1] = 8'h20;
    for (int j = 0; j < plen; j++) img[off+2+j] = pb(j);
    img_len = LW'(off + 2 + plen);
    exp_words = (plen + 2) / 2;
  endtask

  task automatic run_load(input int restart_at, output bit fin);
    rst = 1; repeat (2) @(negedge clk); #1; rst = 0;
    @(negedge clk); #1;
    clr_mon();
    start = 1;
    @(negedge clk); #1;
    start = 0;
    busy0 = busy;
    first_err = (n_err > 0);
    for (int k = 0; k < 3000; k++) begin
      if (n_done + n_err > 0) break;
      start = (k == restart_at);
      @(negedge clk); #1;
    end
    start = 0;
    fin = (n_done + n_err > 0);
    repeat (3) @(negedge clk); #1;
  endtask

  task automatic set_tgt(input logic [3:0] v, input bit r, input int idly, input int iskip,
                         input bit den, input int ddly, input bit drop);
    ver = v; rdy = r; init_dly = idly; init_skip = iskip; done_en = den;
    done_dly = ddly; drop_mode = drop;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!all_done) begin
      errors++;
      $display("FAIL R13 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit fin;
    int ew;
    clr_mon();
    repeat (3) @(negedge clk); #1;
    // R1 reset state
    chk(!busy && !done_pulse && !err_pulse && !tgt_wr, "R1 status", busy, 0);
    chk(!tgt_rst && !tgt_reload && !tgt_prog, "R1 pulses", tgt_prog, 0);
    chk(err_code == 3'd0, "R1 code", int'(err_code), 0);

    // R9 R7 R8 sweep over marker offset, payload length and interface version
    for (int vi = 0; vi < 2; vi++)
      for (int off = 0; off < 4; off++)
        for (int pl2 = 0; pl2 < 4; pl2++) begin
          build(off, 2*pl2);
          set_tgt(vi == 0 ? 4'h5 : 4'h3, 1, 1, 0, 1, 1, 0);
          run_load(-1, fin);
          chk(fin && n_done == 1 && n_err == 0, "R11 success", n_done, 1);
          chk(busy0, "R13 busy after start", busy0, 1);
          chk(nw == exp_words, "R9 word count", nw, exp_words);
          for (int k = 0; k < exp_words && k < nw; k++)
            chk(got[k] == exp_word(k), "R9 word value", int'(got[k]), int'(exp_word(k)));
          chk(n_prog == 1, "R12 single attempt", n_prog, 1);
          if (nw > 1) begin
            ew = (vi == 0) ? 7 : GP + 6;
            chk(gmin == ew && gmax == ew, vi == 0 ? "R7 write spacing" : "R8 write spacing", gmax, ew);
          end
          if (vi == 0 && off == 0 && pl2 == 0) begin
            chk(t_rld - t_rst == PL, "R5 reload after reset", t_rld - t_rst, PL);
            chk(t_prg - t_rld == PL, "R5 prog after reload", t_prg - t_rld, PL);
            chk(prg_w == PL, "R5 prog width", prg_w, PL);
          end
        end

    // R2 storage absent
    build(0, 2); mem_present = 0;
    run_load(-1, fin);
    chk(first_err && last_code == 3'd7, "R2 absent store", int'(last_code), 7);
    chk(n_prog == 0 && !busy0, "R2 no pulses", n_prog, 0);
    mem_present = 1;

    // R3 no marker (near misses), and too short
    img[0] = 8'hFF; img[1] = 8'h21; img[2] = 8'h20; img[3] = 8'hFF; img[4] = 8'hFF;
    img_len = 5;
    run_load(-1, fin);
    chk(fin && n_err == 1 && last_code == 3'd1, "R3 no marker", int'(last_code), 1);
    chk(n_prog == 0, "R3 no pulses", n_prog, 0);
    img_len = 1;
    run_load(-1, fin);
    chk(first_err && last_code == 3'd1, "R3 short image", int'(last_code), 1);

    // R3 first occurrence of marker; R4 odd payload
    img[0] = 8'h20; img[1] = 8'hFF; img[2] = 8'hFF; img[3] = 8'h20;
    img[4] = 8'h11; img[5] = 8'h22; img[6] = 8'h33; img[7] = 8'h44;
    img_len = 8; exp_words = 3;
    set_tgt(4'h5, 1, 1, 0, 1, 1, 0);
    run_load(-1, fin);
    chk(n_done == 1 && nw == 3, "R3 first marker count", nw, 3);
    chk(got[0] == 16'hFF20 && got[1] == 16'h1122 && got[2] == 16'h3344, "R3 first marker words",
        int'(got[2]), 16'h3344);
    img_len = 7;
    run_load(-1, fin);
    chk(n_err == 1 && last_code == 3'd2, "R4 odd payload", int'(last_code), 2);
    chk(n_prog == 0, "R4 no pulses", n_prog, 0);

    // R6 init poll window boundary
    build(1, 4);
    set_tgt(4'h5, 1, IT - 1, 0, 1, 1, 0);
    run_load(-1, fin);
    chk(n_done == 1 && n_prog == 1, "R6 init on last poll", n_done, 1);
    set_tgt(4'h5, 1, IT, 0, 1, 1, 0);
    run_load(-1, fin);
    chk(n_err == 1 && last_code == 3'd3, "R6 init timeout", int'(last_code), 3);
    chk(n_prog == AT && nw == 0, "R12 init retries", n_prog, AT);

    // R7 ready timeout on new interface; R8 ready ignored on old interface
    set_tgt(4'h5, 0, 1, 0, 1, 1, 0);
    run_load(-1, fin);
    chk(n_err == 1 && last_code == 3'd4, "R7 ready timeout", int'(last_code), 4);
    chk(nw == 0 && n_prog == AT, "R7 no writes", nw, 0);
    set_tgt(4'h0, 0, 1, 0, 1, 1, 0);
    run_load(-1, fin);
    chk(n_done == 1 && nw == exp_words, "R8 ready ignored", nw, exp_words);

    // R10 init lost after a write; R12 restart from the marker
    set_tgt(4'h5, 1, 1, 0, 1, 1, 1);
    run_load(-1, fin);
    chk(n_err == 1 && last_code == 3'd5, "R10 init lost", int'(last_code), 5);
    chk(nw == AT && n_prog == AT, "R12 one word per attempt", nw, AT);
    for (int k = 0; k < AT && k < nw; k++)
      chk(got[k] == 16'hFF20, "R12 restart at marker", int'(got[k]), 16'hFF20);

    // R11 done poll window boundary
    set_tgt(4'h5, 1, 1, 0, 1, DT - 1, 0);
    run_load(-1, fin);
    chk(n_done == 1 && n_err == 0, "R11 done on last poll", n_done, 1);
    set_tgt(4'h5, 1, 1, 0, 1, DT, 0);
    run_load(-1, fin);
    chk(n_err == 1 && last_code == 3'd6, "R11 done timeout", int'(last_code), 6);
    chk(nw == AT * exp_words, "R12 full rewrite per attempt", nw, AT * exp_words);

    // R12 success on the last attempt, failure when all attempts are used
    set_tgt(4'h5, 1, 1, AT - 1, 1, 1, 0);
    run_load(-1, fin);
    chk(n_done == 1 && n_prog == AT && nw == exp_words, "R12 late success", n_prog, AT);
    set_tgt(4'h5, 1, 1, AT, 1, 1, 0);
    run_load(-1, fin);
    chk(n_err == 1 && last_code == 3'd3 && n_prog == AT, "R12 attempts exhausted", n_prog, AT);

    // R13 start while busy has no effect
    set_tgt(4'h5, 1, 1, 0, 1, 1, 0);
    run_load(12, fin);
    chk(n_done == 1 && n_err == 0 && n_prog == 1, "R13 restart ignored", n_prog, 1);
    chk(nw == exp_words && !busy, "R13 words unchanged", nw, exp_words);

    all_done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule